// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block works out where a processor goes after a branch instruction. Each cycle it can accept one 32-bit instruction word with its program counter, count register, link register and 32-bit condition register. One clock later it presents a registered result. The result holds the taken flag, the next program counter, a new count register value with its write enable, and a new link register value with its write enable. The surrounding pipeline does the fetching and the register writeback. This unit only evaluates the branch.

Four branch forms are understood:

- an unconditional branch with a 24-bit displacement;
- a conditional branch with a 14-bit displacement;
- a conditional branch to the link register;
- a conditional branch to the count register.

The 5-bit option field (BO) selects several behaviours:

- whether the count register is decremented before the test;
- which polarity of "count is zero" passes;
- which polarity of the chosen condition bit passes;
- whether either test is skipped.

Any other instruction word resolves to a plain fall-through with no register writes.

A small state machine tracks whether a result is being presented:

- State ST_IDLE: no result is presented.
- State ST_RESULT: a result is presented.
- Transition T_ACCEPT (ST_IDLE to ST_RESULT): taken when `in_valid` is high at a clock edge.
- Transition T_NEXT (ST_RESULT to ST_RESULT): taken when a new instruction arrives while a result is shown.
- Transition T_DRAIN (ST_RESULT to ST_IDLE): taken when no new instruction arrives.

Top module: `branch_resolve`

## Requirements
- R1: During and directly after reset, `res_valid`, `taken`, `ctr_we` and `lr_we` are 0.
- R2: An instruction sampled with `in_valid`=1 at a rising edge has its result on the outputs after that edge, with `res_valid`=1. After an edge with `in_valid`=0, `res_valid`, `taken`, `ctr_we` and `lr_we` are 0.
- R3: The count register is decremented when both of these hold:
  - the instruction is a conditional displacement branch (bits[31:26]=16) or a branch to link (bits[31:26]=19, bits[10:1]=16);
  - the BO field (bits[25:21]) has BO[2] clear.
  In that case `ctr_we`=1 and `ctr_new`=ctr-1 (modulo 2^32), and the decremented value is the one the count test uses.
- R4: The count test passes when BO[2] is set. Otherwise it passes when (count value != 0) XOR BO[1] is true.
- R5: The condition test passes when BO[4] is set. Otherwise it passes when cr[31-BI] equals BO[3], where BI is bits[20:16]; BI=0 selects the most significant bit.
- R6: A conditional branch is taken only when both tests pass. When it is not taken, `next_pc`=pc+4.
- R7: Displacement targets work as follows:
  - Opcode 18 is always taken. Its displacement is bits[25:2] shifted left by two and sign-extended.
  - Opcode 16 uses bits[15:2] shifted left by two and sign-extended.
  - The target is pc plus the displacement, unless AA (bit 1) is set, in which case the displacement itself is the target.
- R8: When LK (bit 0) is set on a taken branch, `lr_we`=1 and `lr_new`=pc+4. A branch that is not taken never writes the link register.
- R9: A taken branch to link goes to the incoming link value with bits[1:0] cleared. This holds even when LK is set; the old link value is used.
- R10: A branch to count (bits[31:26]=19, bits[10:1]=528) goes to the count value with bits[1:0] cleared. It never writes the count register, and its count test always passes.
- R11: Any other instruction word gives `taken`=0, `next_pc`=pc+4, `ctr_we`=0 and `lr_we`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| insn | input | 32 | Raw instruction word |
| pc | input | 32 | Address of the instruction |
| ctr_in | input | 32 | Current count register |
| lr_in | input | 32 | Current link register |
| cr_in | input | 32 | Condition register, bit 31 is condition bit 0 |
| res_valid | output | 1 | Result is presented |
| taken | output | 1 | Branch taken |
| next_pc | output | 32 | Address of the next instruction |
| ctr_we | output | 1 | Write enable for the count register |
| ctr_new | output | 32 | New count register value |
| lr_we | output | 1 | Write enable for the link register |
| lr_new | output | 32 | New link register value |

## Verification
The hardest case to reach is a count test that depends on the decrement wrapping or landing on zero. This occurs when the incoming count is 1 or 0, and it interacts with the zero-polarity bit. The sweep drives every BO value against count values 0, 1, 2 and a large value, for each condition-bit polarity, with and without LK, across all three conditional forms. Each of these paths, including the branch to link with LK set where the old link value must win, is therefore visited on purpose.

// File: rtl/br_pkg.sv
package br_pkg;
    localparam int INSN_W = 32;
    localparam int OP_IMM   = 18;
    localparam int OP_COND  = 16;
    localparam int OP_EXT   = 19;
    localparam int XO_TOLR  = 16;
    localparam int XO_TOCTR = 528;

    typedef enum logic [2:0] {
        K_NONE,
        K_IMM,
        K_COND,
        K_TOLR,
        K_TOCTR
    } br_kind_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESULT
    } br_state_e;
endpackage

// File: rtl/br_decode.sv
module br_decode
    import br_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [INSN_W-1:0] insn_i,
    output br_kind_e          kind_o,
    output logic [4:0]        bo_o,
    output logic [4:0]        bi_o,
    output logic              aa_o,
    output logic              lk_o,
    output logic [XLEN-1:0]   disp_o
);
    localparam int LI_W = 24;
    localparam int BD_W = 14;

    logic [5:0]  opcode;
    logic [9:0]  xo;
    logic [LI_W-1:0] li;
    logic [BD_W-1:0] bd;

    assign opcode = insn_i[31:26];
    assign xo     = insn_i[10:1];
    assign li     = insn_i[25:2];
    assign bd     = insn_i[15:2];
    assign bo_o   = insn_i[25:21];
    assign bi_o   = insn_i[20:16];
    assign aa_o   = insn_i[1];
    assign lk_o   = insn_i[0];

    always_comb begin
        kind_o = K_NONE;
        if (opcode == 6'(OP_IMM))
            kind_o = K_IMM;
        else if (opcode == 6'(OP_COND))
            kind_o = K_COND;
        else if (opcode == 6'(OP_EXT) && xo == 10'(XO_TOLR))
            kind_o = K_TOLR;
        else if (opcode == 6'(OP_EXT) && xo == 10'(XO_TOCTR))
            kind_o = K_TOCTR;
    end

    always_comb begin
        if (kind_o == K_IMM)
            disp_o = {{(XLEN-LI_W-2){li[LI_W-1]}}, li, 2'b00};
        else
            disp_o = {{(XLEN-BD_W-2){bd[BD_W-1]}}, bd, 2'b00};
    end
endmodule

// File: rtl/br_cond.sv
module br_cond
    import br_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int CR_W = 32
) (
    input  br_kind_e        kind_i,
    input  logic [4:0]      bo_i,
    input  logic [4:0]      bi_i,
    input  logic [XLEN-1:0] ctr_i,
    input  logic [CR_W-1:0] cr_i,
    output logic            pass_o,
    output logic            ctr_we_o,
    output logic [XLEN-1:0] ctr_next_o
);
    logic            uses_ctr;
    logic [XLEN-1:0] ctr_eff;
    logic            ctr_ok;
    logic            cr_ok;
    logic            cr_bit;

    assign uses_ctr   = (kind_i == K_COND) || (kind_i == K_TOLR);
    assign ctr_we_o   = uses_ctr && !bo_i[2];
    assign ctr_next_o = ctr_i - XLEN'(1);
    assign ctr_eff    = ctr_we_o ? ctr_next_o : ctr_i;
    assign cr_bit     = cr_i[CR_W-1-int'(bi_i)];

    always_comb begin
        ctr_ok = bo_i[2] || (kind_i == K_TOCTR) || ((ctr_eff != '0) ^ bo_i[1]);
        cr_ok  = bo_i[4] || (cr_bit == bo_i[3]);
        unique case (kind_i)
            K_IMM:                  pass_o = 1'b1;
            K_COND, K_TOLR, K_TOCTR: pass_o = ctr_ok && cr_ok;
            default:                pass_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/br_target.sv
module br_target
    import br_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  br_kind_e        kind_i,
    input  logic            aa_i,
    input  logic [XLEN-1:0] disp_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] lr_i,
    input  logic [XLEN-1:0] ctr_i,
    output logic [XLEN-1:0] target_o
);
    localparam logic [XLEN-1:0] WORD_MASK = ~XLEN'(3);

    always_comb begin
        unique case (kind_i)
            K_IMM, K_COND: target_o = aa_i ? disp_i : pc_i + disp_i;
            K_TOLR:        target_o = lr_i & WORD_MASK;
            K_TOCTR:       target_o = ctr_i & WORD_MASK;
            default:       target_o = pc_i + XLEN'(4);
        endcase
    end
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
    import br_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int CR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] insn,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   ctr_in,
    input  logic [XLEN-1:0]   lr_in,
    input  logic [CR_W-1:0]   cr_in,
    output logic              res_valid,
    output logic              taken,
    output logic [XLEN-1:0]   next_pc,
    output logic              ctr_we,
    output logic [XLEN-1:0]   ctr_new,
    output logic              lr_we,
    output logic [XLEN-1:0]   lr_new
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    br_kind_e        dec_kind;
    logic [4:0]      dec_bo;
    logic [4:0]      dec_bi;
    logic            dec_aa;
    logic            dec_lk;
    logic [XLEN-1:0] dec_disp;
    logic            cond_pass;
    logic            cond_ctr_we;
    logic [XLEN-1:0] cond_ctr_next;
    logic [XLEN-1:0] tgt;
    br_state_e       state_q;
    br_state_e       state_d;

    br_decode #(.XLEN(XLEN)) u_decode (
        .insn_i(insn), .kind_o(dec_kind), .bo_o(dec_bo), .bi_o(dec_bi),
        .aa_o(dec_aa), .lk_o(dec_lk), .disp_o(dec_disp)
    );

    br_cond #(.XLEN(XLEN), .CR_W(CR_W)) u_cond (
        .kind_i(dec_kind), .bo_i(dec_bo), .bi_i(dec_bi), .ctr_i(ctr_in),
        .cr_i(cr_in), .pass_o(cond_pass), .ctr_we_o(cond_ctr_we),
        .ctr_next_o(cond_ctr_next)
    );

    br_target #(.XLEN(XLEN)) u_target (
        .kind_i(dec_kind), .aa_i(dec_aa), .disp_i(dec_disp), .pc_i(pc),
        .lr_i(lr_in), .ctr_i(ctr_in), .target_o(tgt)
    );

    // next-state logic: T_ACCEPT, T_NEXT, T_DRAIN
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = in_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    assign res_valid = (state_q == ST_RESULT);

    // registered result outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken   <= 1'b0;
            next_pc <= '0;
            ctr_we  <= 1'b0;
            ctr_new <= '0;
            lr_we   <= 1'b0;
            lr_new  <= '0;
        end else if (in_valid) begin
            taken   <= cond_pass;
            next_pc <= cond_pass ? tgt : pc + STEP;
            ctr_we  <= cond_ctr_we;
            ctr_new <= cond_ctr_next;
            lr_we   <= cond_pass && dec_lk;
            lr_new  <= pc + STEP;
        end else begin
            taken   <= 1'b0;
            ctr_we  <= 1'b0;
            lr_we   <= 1'b0;
        end
    end

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!taken && !ctr_we && !lr_we));

    assert_ctr_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_we |-> (ctr_new == $past(ctr_in) - XLEN'(1)));

    assert_ctr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_kind == K_TOCTR) |=> !ctr_we);

    assert_fallthrough_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !taken) |-> (next_pc == $past(pc) + STEP));

    assert_lr_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lr_we |-> (taken && lr_new == $past(pc) + STEP));

    assert_reg_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (dec_kind == K_TOLR || dec_kind == K_TOCTR)) |=>
        (!taken || next_pc[1:0] == 2'b00));

    assert_other_inert_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_kind == K_NONE) |=> (!taken && !ctr_we && !lr_we));
endmodule

// File: tb/branch_resolve_bench.sv
module branch_resolve_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] insn = '0, pc = '0, ctr_in = '0, lr_in = '0, cr_in = '0;
    logic        res_valid, taken, ctr_we, lr_we;
    logic [31:0] next_pc, ctr_new, lr_new;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    branch_resolve u_branch_resolve (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn), .pc(pc),
        .ctr_in(ctr_in), .lr_in(lr_in), .cr_in(cr_in), .res_valid(res_valid),
        .taken(taken), .next_pc(next_pc), .ctr_we(ctr_we), .ctr_new(ctr_new),
        .lr_we(lr_we), .lr_new(lr_new)
    );

    typedef struct packed {
        logic        tk;
        logic [31:0] npc;
        logic        cwe;
        logic [31:0] cnew;
        logic        lwe;
        logic [31:0] lnew;
    } exp_t;

    function automatic exp_t model(input logic [31:0] w, input logic [31:0] p,
                                   input logic [31:0] c, input logic [31:0] l,
                                   input logic [31:0] cr);
        exp_t e;
        logic [5:0] op = w[31:26];
        logic [9:0] xo = w[10:1];
        logic [4:0] bo = w[25:21];
        logic [4:0] bi = w[20:16];
        logic [31:0] off, tgt, cv;
        logic cok, rok, isctr;
        e = '0;
        e.npc = p + 32'd4;
        e.lnew = p + 32'd4;
        if (op == 6'd18) begin
            off = {{6{w[25]}}, w[25:2], 2'b00};
            e.tk = 1'b1;
            e.npc = w[1] ? off : p + off;
        end else if (op == 6'd16 || (op == 6'd19 && (xo == 10'd16 || xo == 10'd528))) begin
            isctr = (op == 6'd19 && xo == 10'd528);
            cv = c;
            if (!bo[2] && !isctr) begin
                e.cwe = 1'b1;
                cv = c - 32'd1;
                e.cnew = cv;
            end
            cok = bo[2] || isctr || ((cv != 0) != bo[1]);
            rok = bo[4] || (cr[31 - bi] == bo[3]);
            e.tk = cok && rok;
            if (op == 6'd16) begin
                off = {{16{w[15]}}, w[15:2], 2'b00};
                tgt = w[1] ? off : p + off;
            end else if (isctr) tgt = {c[31:2], 2'b00};
            else tgt = {l[31:2], 2'b00};
            if (e.tk) e.npc = tgt;
        end
        e.lwe = e.tk && w[0];
        return e;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_one(input logic [31:0] w, input logic [31:0] p,
                           input logic [31:0] c, input logic [31:0] l,
                           input logic [31:0] cr, input string tag);
        exp_t e = model(w, p, c, l, cr);
        @(negedge clk);
        insn = w; pc = p; ctr_in = c; lr_in = l; cr_in = cr; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " valid R2"}, {31'd0, res_valid}, 32'd1);
        chk({tag, " taken R4 R5 R6"}, {31'd0, taken}, {31'd0, e.tk});
        chk({tag, " next_pc R6 R7 R9 R10"}, next_pc, e.npc);
        chk({tag, " ctr_we R3 R10"}, {31'd0, ctr_we}, {31'd0, e.cwe});
        if (e.cwe) chk({tag, " ctr_new R3"}, ctr_new, e.cnew);
        chk({tag, " lr_we R8"}, {31'd0, lr_we}, {31'd0, e.lwe});
        if (e.lwe) chk({tag, " lr_new R8 R9"}, lr_new, e.lnew);
    endtask

    initial begin
        logic [31:0] ctr_set [4];
        int n;
        ctr_set[0] = 32'd0; ctr_set[1] = 32'd1;
        ctr_set[2] = 32'd2; ctr_set[3] = 32'h8000_0003;
        repeat (3) @(negedge clk);
        chk("reset R1", {28'd0, res_valid, taken, ctr_we, lr_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("after reset R1", {28'd0, res_valid, taken, ctr_we, lr_we}, 32'd0);

        n = 0;
        for (int form = 0; form < 3; form++)
            for (int bo = 0; bo < 32; bo++)
                for (int crv = 0; crv < 2; crv++)
                    for (int ci = 0; ci < 4; ci++)
                        for (int lk = 0; lk < 2; lk++) begin
                            logic [4:0]  bi = 5'((bo * 7 + ci * 3 + form + crv) % 32);
                            logic [13:0] bd = 14'((bo * 613 + ci * 97 + crv * 5000) & 16'h3fff);
                            logic        aa = (ci == 3);
                            logic [31:0] w, cr;
                            cr = 32'hA5C3_0F96 ^ (32'(n) * 32'h0101_0101);
                            cr[31 - bi] = crv[0];
                            if (form == 0) w = {6'd16, 5'(bo), bi, bd, aa, 1'(lk)};
                            else if (form == 1) w = {6'd19, 5'(bo), bi, 5'd0, 10'd16, 1'(lk)};
                            else w = {6'd19, 5'(bo), bi, 5'd0, 10'd528, 1'(lk)};
                            run_one(w, 32'h4000_0000 + 32'(n) * 4, ctr_set[ci] ^ (form == 2 ? 32'h0000_1233 : 0),
                                    32'h2000_1003 + 32'(bo) * 16, cr,
                                    form == 0 ? "disp R7" : (form == 1 ? "tolr R9" : "toctr R10"));
                            n++;
                        end

        for (int k = 0; k < 16; k++) begin
            logic [23:0] li = (k[0]) ? 24'hFF_FFF0 - 24'(k * 8) : 24'h00_0040 + 24'(k * 40);
            run_one({6'd18, li, 1'(k >> 1), 1'(k >> 2)}, 32'h0010_0000 + 32'(k) * 64,
                    32'd7, 32'h55, 32'h0, "imm R7");
        end

        run_one({6'd31, 5'd3, 5'd4, 5'd5, 10'd266, 1'b0}, 32'h100, 32'd1, 32'h77, 32'hFFFF_FFFF, "other R11");
        run_one({6'd19, 5'd20, 5'd0, 5'd0, 10'd150, 1'b1}, 32'h204, 32'd0, 32'h88, 32'h0, "other R11");
        run_one({6'd17, 26'h2}, 32'h308, 32'd5, 32'h99, 32'h0, "other R11");

        @(negedge clk);
        chk("idle R2", {28'd0, res_valid, taken, ctr_we, lr_we}, 32'd0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog expired, R2 actual=hung expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule